// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Function Decode

This block is a purely combinational integer arithmetic-logic unit with a small operation decoder in front of it. A controller supplies a 2-bit operation class and a 6-bit function field. The class can force an addition or a subtraction, which a controller uses for address and comparison work. It can also pass the choice to the function field, which names one of five operations: add, subtract, bitwise AND, bitwise OR and signed set-on-less-than.

Both operands are `WIDTH` bits wide, with a default of 32. Beside the result the unit drives two flags. One is a zero flag, taken from the result. The other is a signed overflow flag, which is meaningful only for add and subtract. Internally the decoder produces a 3-bit select: 000 AND, 001 OR, 010 add, 110 subtract, 111 set-on-less-than. Its top bit also serves as the adder's invert-and-carry-in control.

Top module: `alu_fdec`

## Requirements
- R1: With class 00 the result is the sum of the two operands modulo 2^WIDTH, whatever the function field holds.
- R2: With class 01 the result is operand A minus operand B modulo 2^WIDTH, whatever the function field holds.
- R3: With class 10, function 100000 gives the sum and function 100010 gives A minus B.
- R4: With class 10, function 100100 gives the bitwise AND of the operands and function 100101 gives the bitwise OR.
- R5: With class 10 and function 101010, the result is 1 in bit 0 and 0 elsewhere when A is below B as signed two's-complement numbers, and all zeros otherwise. The answer is correct even when the internal difference overflows.
- R6: The zero output is 1 exactly when every result bit is 0. This holds for every operation.
- R7: For add and subtract, the overflow output is 1 exactly when the true signed result falls outside the signed range of WIDTH bits.
- R8: For AND, OR and set-on-less-than, the overflow output is 0.
- R9: Class 11, and class 10 with any function code other than the five listed above, behave as add, including the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| op_class | input | 2 | Operation class: 00 add, 01 subtract, 10 use function field, 11 add |
| func | input | 6 | Function field, used only when the class is 10 |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The embedded checks are immediate assertions. They assume the inputs are two-valued and are evaluated only after all inputs have settled. The bench therefore drives every input from one task just after a clock edge and compares only at the following falling edge. The stimulus holds at most one change per cycle, so there is no intermediate mix of old and new operands. It walks the signed extremes, zero and minus one through every class and every listed function code. It also uses unlisted codes and random operands, so all overflow and sign cases of the comparison are reached.

// File: rtl/alu_fdec.sv
module alu_fdec #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       op_class,
  input  logic [5:0]       func,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  localparam logic [2:0] SEL_AND = 3'b000;
  localparam logic [2:0] SEL_OR  = 3'b001;
  localparam logic [2:0] SEL_ADD = 3'b010;
  localparam logic [2:0] SEL_SUB = 3'b110;
  localparam logic [2:0] SEL_SLT = 3'b111;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  logic [2:0]       sel;
  logic             negate;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             sum_ovf;
  logic             less;

  always_comb begin
    unique case (op_class)
      2'b01:   sel = SEL_SUB;
      2'b10: begin
        unique case (func)
          FN_SUB:  sel = SEL_SUB;
          FN_AND:  sel = SEL_AND;
          FN_OR:   sel = SEL_OR;
          FN_SLT:  sel = SEL_SLT;
          default: sel = SEL_ADD;
        endcase
      end
      default: sel = SEL_ADD;
    endcase
  end

  assign negate  = sel[2];
  assign b_eff   = opb ^ {WIDTH{negate}};
  assign sum     = opa + b_eff + {{(WIDTH-1){1'b0}}, negate};
  assign sum_ovf = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
  assign less    = sum[MSB] ^ sum_ovf;

  always_comb begin
    unique case (sel)
      SEL_AND: result = opa & opb;
      SEL_OR:  result = opa | opb;
      SEL_SLT: result = {{(WIDTH-1){1'b0}}, less};
      default: result = sum;
    endcase
  end

  assign zero = ~|result;
  assign ovf  = (sel == SEL_ADD || sel == SEL_SUB) ? sum_ovf : 1'b0;

  always_comb begin
    if (op_class == 2'b00)
      a_r1_class_add: assert (result == opa + opb);
    if (op_class == 2'b01)
      a_r2_class_sub: assert (result == opa - opb);
    if (op_class == 2'b10 && func == FN_SLT)
      a_r5_slt_upper_clear: assert (result[MSB:1] == '0);
    if (op_class == 2'b10 && (func == FN_AND || func == FN_OR || func == FN_SLT))
      a_r8_no_overflow: assert (!ovf);
    if (op_class == 2'b00 && ovf)
      a_r7_add_ovf_signs: assert (opa[MSB] == opb[MSB] && result[MSB] != opa[MSB]);
    if (zero)
      a_r6_zero_result: assert (result == '0);
  end
endmodule

// File: tb/tb_alu_fdec.sv
module tb_alu_fdec;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] opa, opb;
  logic [1:0]   op_class;
  logic [5:0]   func;
  logic [W-1:0] result;
  logic         zero, ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  alu_fdec #(.WIDTH(W)) dut (
    .opa(opa), .opb(opb), .op_class(op_class), .func(func),
    .result(result), .zero(zero), .ovf(ovf)
  );

  // op: 0 add, 1 sub, 2 and, 3 or, 4 slt
  function automatic int ref_op(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b01) return 1;
    if (c != 2'b10) return 0;
    case (f)
      6'b100000: return 0;
      6'b100010: return 1;
      6'b100100: return 2;
      6'b100101: return 3;
      6'b101010: return 4;
      default:   return 0;
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] c, input logic [5:0] f, input int op);
    if (c == 2'b00) return "R1";
    if (c == 2'b01) return "R2";
    if (c == 2'b11) return "R9";
    case (op)
      0: return (f == 6'b100000) ? "R3" : "R9";
      1: return "R3";
      4: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic fail_line(input string req, input string what, input longint act, input longint exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h (a=%h b=%h class=%b func=%b)",
             req, what, act, exp, opa, opb, op_class, func);
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] c, input logic [5:0] f);
    int op;
    longint sa, sb, wide;
    logic [W-1:0] e_res;
    logic e_ovf;
    string tag;
    @(posedge clk);
    #1;
    opa = a; opb = b; op_class = c; func = f;
    op = ref_op(c, f);
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    e_ovf = 1'b0;
    case (op)
      0: begin wide = sa + sb; e_res = a + b; e_ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      1: begin wide = sa - sb; e_res = a - b; e_ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      2: e_res = a & b;
      3: e_res = a | b;
      default: e_res = (sa < sb) ? 32'd1 : 32'd0;
    endcase
    tag = op_tag(c, f, op);
    @(negedge clk);
    checks++;
    if (result !== e_res) fail_line(tag, "result", longint'(result), longint'(e_res));
    checks++;
    if (zero !== (e_res == 0)) fail_line("R6", "zero", longint'(zero), longint'(e_res == 0));
    checks++;
    if (ovf !== e_ovf) fail_line((op <= 1) ? "R7" : "R8", "ovf", longint'(ovf), longint'(e_ovf));
  endtask

  initial begin
    logic [W-1:0] corners [8];
    logic [5:0]   codes [8];
    corners = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                32'h8000_0000, 32'h8000_0001, 32'h0000_FFFF, 32'h5555_AAAA};
    codes   = '{6'b100000, 6'b100010, 6'b100100, 6'b100101,
                6'b101010, 6'b000000, 6'b111111, 6'b101011};
    opa = '0; opb = '0; op_class = 2'b00; func = 6'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: idle zero inputs give a zero sum with zero flag set (R6)
    @(negedge clk);
    checks++;
    if (result !== '0 || zero !== 1'b1 || ovf !== 1'b0)
      fail_line("R6", "idle", longint'({result, zero, ovf}), 64'h2);
    // R5 overflow-crossing comparisons and R7 boundaries
    apply(32'h8000_0000, 32'h0000_0001, 2'b10, 6'b101010);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b10, 6'b101010);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 2'b00, 6'b000000);
    apply(32'h8000_0000, 32'h0000_0001, 2'b01, 6'b100100);
    apply(32'h0000_0005, 32'h0000_0005, 2'b01, 6'b000000);
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 8; k++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            apply(corners[i], corners[j], 2'(c), codes[k]);
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] f;
      f = (n % 3 == 0) ? 6'($urandom) : codes[$urandom % 5];
      apply($urandom, (n % 7 == 0) ? 32'h8000_0000 : $urandom, 2'($urandom), f);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule